// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit holds the stack pointer of a small 8-bit processor. The stack grows toward lower addresses. On a byte push the data goes to the address the pointer holds, and the pointer then moves down by one, so the pointer always names the next free location. A byte pop first moves the pointer up by one and then reads there. Calls and interrupt entries store a two-byte return address and lower the pointer by two. Returns raise it by two. For these two-byte accesses the unit presents one address for each byte. The low byte of the return address sits at the higher address, and a return reads the two bytes back in the reverse order.

Software sees the pointer as two bytes on a byte-wide I/O bus: the low byte at a base offset and the high byte at the next offset. Only the low 12 bits of the pointer are stored. The upper four bits read as zero and drop whatever is written to them. All pins are plain level or strobe pins with no handshake. Each strobe lasts one clock cycle and acts at the next rising edge. The address outputs are combinational from the current pointer and the strobes, so they are valid in the same cycle as the strobe. Bus reads are also combinational. A bus write takes effect at the next edge.

Top module: `stack_ptr_unit`

## Requirements
- R1: A byte push (push_i) sets byte_addr_o to the current pointer in that cycle, and the pointer is one lower after the next clock edge.
- R2: A byte pop (pop_i) sets byte_addr_o to the current pointer plus one in that cycle, and the pointer is one higher after the next clock edge.
- R3: A call or interrupt entry (call_i) sets ra_lo_addr_o to the current pointer and ra_hi_addr_o to the pointer minus one in that cycle. The pointer is two lower after the next edge.
- R4: A return (ret_i) sets ra_hi_addr_o to the current pointer plus one and ra_lo_addr_o to the pointer plus two in that cycle. The pointer is two higher after the next edge.
- R5: After reset the pointer reads 0x08FF.
- R6: A bus read at offset 0x3D returns pointer bits 7:0, and a read at 0x3E returns bits 15:8. A read at any other offset returns 0x00. A write with bus_we_i at 0x3D or 0x3E replaces that byte of the pointer from the next edge.
- R7: Pointer bits 15:12 always read as zero. Values written to those bits are dropped.
- R8: When a push, pop, call or return strobe is active, a bus write in the same cycle is discarded, and the adjustment alone takes place.
- R9: When several strobes are active together, only one takes effect, in this priority: call first, then return, then push, then pop.
- R10: Pointer arithmetic wraps modulo 4096. A push at 0x000 gives 0xFFF, and a pop at 0xFFF gives 0x000.
- R11: With no strobe and no bus write to the pointer offsets, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Byte push strobe |
| pop_i | input | 1 | Byte pop strobe |
| call_i | input | 1 | Call or interrupt entry strobe (two-byte push) |
| ret_i | input | 1 | Return strobe (two-byte pop) |
| bus_addr_i | input | 6 | I/O bus offset |
| bus_we_i | input | 1 | I/O bus write enable |
| bus_wdata_i | input | 8 | I/O bus write data |
| bus_rdata_o | output | 8 | I/O bus read data, combinational |
| sp_o | output | 16 | Current stack pointer |
| byte_addr_o | output | 16 | Memory address for a byte push or pop |
| ra_lo_addr_o | output | 16 | Memory address of the return-address low byte |
| ra_hi_addr_o | output | 16 | Memory address of the return-address high byte |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer with 12 stored bits, a reset value of 0x08FF and a bus base offset of 0x3D. With only 12 stored bits, a single bus write to 0x000 or 0xFFF makes both wrap directions reachable within a few cycles. Random strobe mixes that also carry bus writes exercise the priority between strobes and the rule that a strobe beats a bus write across thousands of cycles.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_CALL,
    OP_RET
  } stk_op_e;
endpackage

// File: rtl/stkp_cmd_decode.sv
module stkp_cmd_decode
  import stkp_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    call_i,
  input  logic    ret_i,
  output stk_op_e op_o
);
  always_comb begin
    if (call_i)      op_o = OP_CALL;
    else if (ret_i)  op_o = OP_RET;
    else if (push_i) op_o = OP_PUSH;
    else if (pop_i)  op_o = OP_POP;
    else             op_o = OP_IDLE;
  end

  // R9: a call strobe always wins over every other strobe
  always_comb begin
    if (call_i) begin
      a_call_wins_r9: assert (op_o == OP_CALL);
    end
  end
endmodule

// File: rtl/stkp_reg.sv
module stkp_reg
  import stkp_pkg::*;
#(
  parameter int unsigned           SP_W    = 12,
  parameter int unsigned           NBYTES  = 2,
  parameter logic [SP_W-1:0]       RST_SP  = 12'h8FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  input  logic [NBYTES-1:0] wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [SP_W-1:0]   sp_o
);
  logic [SP_W-1:0] sp_q, sp_d, wr_sp;

  for (genvar b = 0; b < SP_W; b++) begin : g_bit
    assign wr_sp[b] = wr_en_i[b / 8] ? wdata_i[b % 8] : sp_q[b];
  end

  always_comb begin
    unique case (op_i)
      OP_PUSH: sp_d = sp_q - SP_W'(1);
      OP_POP:  sp_d = sp_q + SP_W'(1);
      OP_CALL: sp_d = sp_q - SP_W'(2);
      OP_RET:  sp_d = sp_q + SP_W'(2);
      default: sp_d = wr_sp;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= RST_SP;
    else        sp_q <= sp_d;
  end

  assign sp_o = sp_q;

  // R11: idle with no lane write keeps the pointer
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE && wr_en_i == '0) |=> $stable(sp_q));
endmodule

// File: rtl/stkp_addr_gen.sv
module stkp_addr_gen
  import stkp_pkg::*;
#(
  parameter int unsigned SP_W = 12
) (
  input  stk_op_e         op_i,
  input  logic [SP_W-1:0] sp_i,
  output logic [SP_W-1:0] byte_addr_o,
  output logic [SP_W-1:0] ra_lo_addr_o,
  output logic [SP_W-1:0] ra_hi_addr_o
);
  logic [SP_W-1:0] sp_up1, sp_up2, sp_dn1;

  assign sp_up1 = sp_i + SP_W'(1);
  assign sp_up2 = sp_i + SP_W'(2);
  assign sp_dn1 = sp_i - SP_W'(1);

  always_comb begin
    byte_addr_o  = (op_i == OP_POP) ? sp_up1 : sp_i;
    ra_lo_addr_o = (op_i == OP_RET) ? sp_up2 : sp_i;
    ra_hi_addr_o = (op_i == OP_RET) ? sp_up1 : sp_dn1;
  end

  // R3 and R4: the two return-address bytes sit on adjacent locations
  always_comb begin
    if (op_i == OP_CALL || op_i == OP_RET) begin
      a_ra_adjacent_r3: assert (ra_lo_addr_o == ra_hi_addr_o + SP_W'(1));
    end
  end
endmodule

// File: rtl/stkp_bus_port.sv
module stkp_bus_port
  import stkp_pkg::*;
#(
  parameter int unsigned BUS_AW   = 6,
  parameter int unsigned BASE_OFS = 'h3D,
  parameter int unsigned NBYTES   = 2
) (
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  stk_op_e             op_i,
  input  logic [NBYTES*8-1:0] sp_full_i,
  output logic [NBYTES-1:0]   wr_en_o,
  output logic [7:0]          rdata_o
);
  logic [NBYTES-1:0] hit;
  logic [7:0]        lane_rd [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign hit[i]     = (bus_addr_i == BUS_AW'(BASE_OFS + i));
    assign wr_en_o[i] = bus_we_i && hit[i] && (op_i == OP_IDLE);
    assign lane_rd[i] = hit[i] ? sp_full_i[i*8 +: 8] : 8'h00;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NBYTES; i++) rdata_o = rdata_o | lane_rd[i];
  end

  // R6: at most one byte lane answers one offset
  always_comb begin
    a_one_lane_r6: assert ($onehot0(hit));
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stkp_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       SP_W     = 12,
  parameter logic [ADDR_W-1:0] RESET_VAL = 16'h08FF,
  parameter int unsigned       BUS_AW   = 6,
  parameter int unsigned       BASE_OFS = 'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [ADDR_W-1:0] ra_lo_addr_o,
  output logic [ADDR_W-1:0] ra_hi_addr_o
);
  localparam int unsigned     NBYTES = ADDR_W / 8;
  localparam logic [SP_W-1:0] RST_SP = RESET_VAL[SP_W-1:0];

  stk_op_e           op;
  logic [SP_W-1:0]   sp;
  logic [NBYTES-1:0] wr_en;
  logic [SP_W-1:0]   byte_a, ra_lo_a, ra_hi_a;

  stkp_cmd_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op)
  );

  stkp_bus_port #(.BUS_AW(BUS_AW), .BASE_OFS(BASE_OFS), .NBYTES(NBYTES)) u_bus (
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .op_i       (op),
    .sp_full_i  (sp_o),
    .wr_en_o    (wr_en),
    .rdata_o    (bus_rdata_o)
  );

  stkp_reg #(.SP_W(SP_W), .NBYTES(NBYTES), .RST_SP(RST_SP)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .wr_en_i (wr_en),
    .wdata_i (bus_wdata_i),
    .sp_o    (sp)
  );

  stkp_addr_gen #(.SP_W(SP_W)) u_addr (
    .op_i         (op),
    .sp_i         (sp),
    .byte_addr_o  (byte_a),
    .ra_lo_addr_o (ra_lo_a),
    .ra_hi_addr_o (ra_hi_a)
  );

  assign sp_o         = ADDR_W'(sp);
  assign byte_addr_o  = ADDR_W'(byte_a);
  assign ra_lo_addr_o = ADDR_W'(ra_lo_a);
  assign ra_hi_addr_o = ADDR_W'(ra_hi_a);

  // R1
  p_push_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !call_i && !ret_i) |=> sp_o[SP_W-1:0] == $past(sp_o[SP_W-1:0]) - SP_W'(1));
  // R2
  p_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !call_i && !ret_i) |=> sp_o[SP_W-1:0] == $past(sp_o[SP_W-1:0]) + SP_W'(1));
  // R3
  p_call_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> sp_o[SP_W-1:0] == $past(sp_o[SP_W-1:0]) - SP_W'(2));
  // R4
  p_ret_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> sp_o[SP_W-1:0] == $past(sp_o[SP_W-1:0]) + SP_W'(2));
  // R7
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[ADDR_W-1:SP_W] == '0);
  // R1: a push addresses the pointer itself
  p_push_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !call_i && !ret_i) |-> byte_addr_o == sp_o);
endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0;
  logic [5:0]  bus_addr_i = 6'h00;
  logic        bus_we_i = 0;
  logic [7:0]  bus_wdata_i = 8'h00;
  logic [7:0]  bus_rdata_o;
  logic [15:0] sp_o, byte_addr_o, ra_lo_addr_o, ra_hi_addr_o;

  int errors = 0;
  int checks = 0;
  logic [11:0] m_sp;

  always #2 clk = ~clk;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .call_i(call_i), .ret_i(ret_i), .bus_addr_i(bus_addr_i),
    .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .sp_o(sp_o), .byte_addr_o(byte_addr_o), .ra_lo_addr_o(ra_lo_addr_o),
    .ra_hi_addr_o(ra_hi_addr_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 idle, 1 push, 2 pop, 3 call, 4 ret (priority of R9)
  function automatic int eff_op(input logic pu, po, ca, re);
    if (ca) return 3;
    if (re) return 4;
    if (pu) return 1;
    if (po) return 2;
    return 0;
  endfunction

  function automatic logic [11:0] next_sp(input logic [11:0] s, input int op,
      input logic we, input logic [5:0] a, input logic [7:0] d);
    case (op)
      1: return s - 12'd1;
      2: return s + 12'd1;
      3: return s - 12'd2;
      4: return s + 12'd2;
      default: begin
        if (we && a == 6'h3D) return {s[11:8], d};
        if (we && a == 6'h3E) return {d[3:0], s[7:0]};
        return s;
      end
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [11:0] s, input logic [5:0] a);
    if (a == 6'h3D) return s[7:0];
    if (a == 6'h3E) return {4'h0, s[11:8]};
    return 8'h00;
  endfunction

  task automatic step(input logic pu, po, ca, re, we, input logic [5:0] a,
                      input logic [7:0] d);
    int op;
    @(negedge clk);
    push_i = pu; pop_i = po; call_i = ca; ret_i = re;
    bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    #1;
    op = eff_op(pu, po, ca, re);
    chk("R11 pointer", sp_o, {4'h0, m_sp});
    chk("R6 read", {8'h00, bus_rdata_o}, {8'h00, exp_rd(m_sp, a)});
    case (op)
      1: chk("R1 push addr", byte_addr_o, {4'h0, m_sp});
      2: chk("R2 pop addr", byte_addr_o, {4'h0, m_sp + 12'd1});
      3: begin
        chk("R3 lo addr", ra_lo_addr_o, {4'h0, m_sp});
        chk("R3 hi addr", ra_hi_addr_o, {4'h0, m_sp - 12'd1});
      end
      4: begin
        chk("R4 hi addr", ra_hi_addr_o, {4'h0, m_sp + 12'd1});
        chk("R4 lo addr", ra_lo_addr_o, {4'h0, m_sp + 12'd2});
      end
      default: ;
    endcase
    @(posedge clk);
    m_sp = next_sp(m_sp, op, we, a, d);
    #1;
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; bus_we_i = 0;
  endtask

  task automatic expect_sp(input string tag, input logic [15:0] v);
    @(negedge clk);
    #1;
    chk(tag, sp_o, v);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    step(0, 0, 0, 0, 1, a, d);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    m_sp = 12'h8FF;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset value", sp_o, 16'h08FF);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 / R6 reset readback through the bus
    step(0, 0, 0, 0, 0, 6'h3D, 8'h00);
    chk("R5 low byte", {8'h00, bus_rdata_o}, 16'h00FF);
    step(0, 0, 0, 0, 0, 6'h3E, 8'h00);
    step(0, 0, 0, 0, 0, 6'h3F, 8'h00);

    // R1 R2 R3 R4 directed
    step(1, 0, 0, 0, 0, 6'h00, 8'h00);
    expect_sp("R1 after push", 16'h08FE);
    step(0, 1, 0, 0, 0, 6'h00, 8'h00);
    expect_sp("R2 after pop", 16'h08FF);
    step(0, 0, 1, 0, 0, 6'h00, 8'h00);
    expect_sp("R3 after call", 16'h08FD);
    step(0, 0, 0, 1, 0, 6'h00, 8'h00);
    expect_sp("R4 after ret", 16'h08FF);

    // R7 upper bits dropped
    wr(6'h3E, 8'hFF);
    expect_sp("R7 high write", 16'h0FFF);
    step(0, 0, 0, 0, 0, 6'h3E, 8'h00);
    chk("R7 high read", {8'h00, bus_rdata_o}, 16'h000F);

    // R10 wrap
    wr(6'h3D, 8'h00);
    wr(6'h3E, 8'h00);
    expect_sp("R6 write both", 16'h0000);
    step(1, 0, 0, 0, 0, 6'h00, 8'h00);
    expect_sp("R10 push wrap", 16'h0FFF);
    step(0, 1, 0, 0, 0, 6'h00, 8'h00);
    expect_sp("R10 pop wrap", 16'h0000);
    wr(6'h3D, 8'h01);
    step(0, 0, 1, 0, 0, 6'h00, 8'h00);
    expect_sp("R10 call wrap", 16'h0FFF);
    step(0, 0, 0, 1, 0, 6'h00, 8'h00);
    expect_sp("R10 ret wrap", 16'h0001);

    // R8 adjustment beats bus write
    wr(6'h3D, 8'h40);
    step(1, 0, 0, 0, 1, 6'h3D, 8'h55);
    expect_sp("R8 push vs write", 16'h003F);
    step(0, 0, 0, 1, 1, 6'h3E, 8'h07);
    expect_sp("R8 ret vs write", 16'h0041);

    // R9 priority
    step(1, 0, 1, 0, 0, 6'h00, 8'h00);
    expect_sp("R9 call over push", 16'h003F);
    step(0, 1, 0, 1, 0, 6'h00, 8'h00);
    expect_sp("R9 ret over pop", 16'h0041);
    step(1, 1, 0, 0, 0, 6'h00, 8'h00);
    expect_sp("R9 push over pop", 16'h0040);
    step(1, 1, 1, 1, 0, 6'h00, 8'h00);
    expect_sp("R9 call over all", 16'h003E);

    // R11 idle hold
    repeat (3) step(0, 0, 0, 0, 0, 6'h3C, 8'h00);
    expect_sp("R11 hold", 16'h003E);
    step(0, 0, 0, 0, 1, 6'h3F, 8'hAA);
    expect_sp("R11 write elsewhere", 16'h003E);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      int r;
      r = $urandom % 4;
      a = 6'h3C + 6'(r);
      step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 8) == 0,
           ($urandom % 8) == 0, ($urandom % 3) == 0, a, 8'($urandom));
    end
    expect_sp("R11 final", {4'h0, m_sp});
    finish_run();
  end
endmodule